// File: doc/BRIEF.md
# Square-Root Seed Generator

This block turns a 32-bit unsigned integer into a single-precision floating-point first guess for its square root. A Newton-style refinement loop then starts from this guess. A good starting point cuts the number of refinement steps, so the block finds the bit length of the input with a leading-zero count. It then shifts the input right by half that length. That leaves an integer whose magnitude is close to the true root.

That integer is converted to IEEE-754 single precision using a second leading-zero count. The count sets the exponent directly and left-aligns the significand in one step. No bit-by-bit normalising loop is used. The result is always positive. A zero input has no useful seed, so the block flags it as invalid and returns +0.0.

The interface is a two-stage pipeline. A one-cycle `start_i` pulse captures the input, and `done_o` pulses two cycles later with the result. A new start may be issued every cycle. Between results the outputs hold their last value.

Top module: `sqrt_seed_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `done_o`, `invalid_o` and `seed_o` are all 0.
- R2: `done_o` is high for exactly one cycle, in the second cycle after the cycle in which `start_i` was sampled high, and never otherwise.
- R3: The integer seed is the input shifted right logically by floor((32 − lz)/2), where lz is the number of leading zero bits of the input.
- R4: `seed_o[30:23]` (biased exponent) equals 158 − lz(s), where s is the integer seed.
- R5: `seed_o[31]` (sign) is always 0.
- R6: `seed_o[22:0]` holds the 23 bits directly below the leading one of the integer seed, left-aligned and zero-filled, with the leading one itself dropped, so that `seed_o` is exactly the float value of the integer seed.
- R7: A zero input yields `invalid_o` = 1 and `seed_o` = 32'h0000_0000 with its `done_o` pulse. Any nonzero input yields `invalid_o` = 0.
- R8: `seed_o` and `invalid_o` change only in a cycle where `done_o` is high, and are otherwise held.
- R9: Starts in consecutive cycles produce `done_o` in consecutive cycles, each result matching its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture `value_i` this cycle |
| value_i | input | 32 | Unsigned integer operand |
| done_o | output | 1 | Result valid pulse |
| seed_o | output | 32 | Single-precision seed |
| invalid_o | output | 1 | Operand was zero |

## Verification
A miscounted leading-zero value shows up in the exponent field of the very result that used it. If it feeds the halving step, it also changes the significand, because the seed integer is then shifted by the wrong amount. A fault in the valid pipe shows as `done_o` arriving one cycle early or late, or pulsing twice, on the first start. A stage register that loads when it should not shows as the outputs moving between `done_o` pulses. Vectors with bit lengths that are odd, even, 1 and 32 separate the halving from the exponent arithmetic.

// File: rtl/sqrt_seed_pkg.sv
package sqrt_seed_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned BIAS   = 127;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } sp_float_t;
endpackage

// File: rtl/lead_zero_cnt.sv
module lead_zero_cnt #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] count_o
);
  localparam int unsigned STAGES = $clog2(W);

  logic [W-1:0] smear [STAGES+1];
  assign smear[0] = data_i;

  // fill every bit below the leading one
  for (genvar g = 0; g < STAGES; g++) begin : g_smear
    assign smear[g+1] = smear[g] | (smear[g] >> (1 << g));
  end

  logic [CW-1:0] ones;
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CW'(smear[STAGES][i]);
  end

  assign count_o = CW'(W) - ones;

  always_comb begin
    if (!$isunknown(data_i) && data_i != '0) begin
      a_r4_lead_one_at_count: assert (data_i[W-1-int'(count_o)] == 1'b1);
      a_r4_none_above: assert ((data_i >> (W - int'(count_o))) == '0 || count_o == '0);
    end
  end
endmodule

// File: rtl/uint_to_sp.sv
module uint_to_sp
  import sqrt_seed_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] int_i,
  output sp_float_t    flt_o
);
  localparam int unsigned CW    = $clog2(W + 1);
  localparam int unsigned ALIGN = W - FRAC_W - 1;  // clz that puts the lead one at FRAC_W

  logic [CW-1:0] lz;
  logic [W-1:0]  aligned;

  lead_zero_cnt #(.W(W), .CW(CW)) u_lz (
    .data_i  (int_i),
    .count_o (lz)
  );

  always_comb begin
    if (int'(lz) >= int'(ALIGN)) aligned = int_i << (int'(lz) - int'(ALIGN));
    else                         aligned = int_i >> (int'(ALIGN) - int'(lz));
  end

  always_comb begin
    flt_o.sign = 1'b0;
    if (int_i == '0) begin
      flt_o.expo = '0;
      flt_o.frac = '0;
    end else begin
      flt_o.expo = EXP_W'(int'(BIAS) + int'(W) - 1 - int'(lz));
      flt_o.frac = aligned[FRAC_W-1:0];
    end
  end

  always_comb begin
    if (!$isunknown(int_i) && int_i != '0) begin
      a_r6_hidden_bit: assert (aligned[FRAC_W] == 1'b1);
    end
  end
endmodule

// File: rtl/sqrt_seed_gen.sv
module sqrt_seed_gen
  import sqrt_seed_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] value_i,
  output logic        done_o,
  output logic [31:0] seed_o,
  output logic        invalid_o
);
  logic [CNT_W-1:0]  in_lz;
  logic [CNT_W-1:0]  half_len;
  logic [WORD_W-1:0] root_int;

  lead_zero_cnt #(.W(WORD_W), .CW(CNT_W)) u_in_lz (
    .data_i  (value_i),
    .count_o (in_lz)
  );

  assign half_len = (CNT_W'(WORD_W) - in_lz) >> 1;
  assign root_int = value_i >> half_len;

  // stage 1: integer seed
  logic              s1_vld;
  logic              s1_zero;
  logic [WORD_W-1:0] s1_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_zero <= 1'b0;
      s1_int  <= '0;
    end else begin
      s1_vld <= start_i;
      if (start_i) begin
        s1_zero <= (value_i == '0);
        s1_int  <= root_int;
      end
    end
  end

  sp_float_t s1_flt;

  uint_to_sp #(.W(WORD_W)) u_conv (
    .int_i (s1_int),
    .flt_o (s1_flt)
  );

  // stage 2: registered result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      seed_o    <= '0;
      invalid_o <= 1'b0;
    end else begin
      done_o <= s1_vld;
      if (s1_vld) begin
        seed_o    <= s1_flt;
        invalid_o <= s1_zero;
      end
    end
  end

  a_r2_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i, 2) |-> done_o);
  a_r2_no_stray_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2));
  a_r5_sign_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_o[31]);
  a_r7_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> seed_o == '0);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(seed_o) && $stable(invalid_o)));
endmodule

// File: tb/tb_sqrt_seed_gen.sv
module tb_sqrt_seed_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] value_i = '0;
  logic        done_o;
  logic [31:0] seed_o;
  logic        invalid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  sqrt_seed_gen dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .value_i   (value_i),
    .done_o    (done_o),
    .seed_o    (seed_o),
    .invalid_o (invalid_o)
  );

  localparam int NV = 9;
  localparam logic [31:0] VIN [NV] = '{
    32'd1, 32'd2, 32'd4, 32'd36, 32'd500, 32'd1160030,
    32'h8000_0000, 32'hFFFF_FFFF, 32'd3
  };
  localparam logic [31:0] VEXP [NV] = '{
    32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, 32'h4080_0000, 32'h41F8_0000,
    32'h448D_8000, 32'h4700_0000, 32'h477F_FF00, 32'h3F80_0000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start at one negedge, result visible at the third negedge
  task automatic run(input logic [31:0] v, input logic [31:0] e_seed, input logic e_inv);
    @(negedge clk_i);
    start_i = 1'b1;
    value_i = v;
    @(negedge clk_i);
    start_i = 1'b0;
    value_i = 32'hA5A5_5A5A;
    chk("R2 early", {31'd0, done_o}, 32'd0);
    @(negedge clk_i);
    chk("R2 done", {31'd0, done_o}, 32'd1);
    chk("R3 R4 R6 seed", seed_o, e_seed);
    chk("R5 sign", {31'd0, seed_o[31]}, 32'd0);
    chk("R7 invalid", {31'd0, invalid_o}, {31'd0, e_inv});
    @(negedge clk_i);
    chk("R2 single pulse", {31'd0, done_o}, 32'd0);
    chk("R8 held", seed_o, e_seed);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", {31'd0, done_o}, 32'd0);
    chk("R1 seed in reset", seed_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 done idle", {31'd0, done_o}, 32'd0);
    chk("R1 invalid idle", {31'd0, invalid_o}, 32'd0);
    chk("R1 seed idle", seed_o, 32'd0);

    for (int i = 0; i < NV; i++) run(VIN[i], VEXP[i], 1'b0);

    // R7 zero operand
    run(32'd0, 32'd0, 1'b1);
    run(32'd36, 32'h4080_0000, 1'b0);

    // R8: input toggling without start leaves outputs alone
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      value_i = 32'h1234_5678 + 32'(i);
    end
    @(negedge clk_i);
    chk("R8 no start", seed_o, 32'h4080_0000);
    chk("R8 no done", {31'd0, done_o}, 32'd0);

    // R9 back-to-back
    @(negedge clk_i);
    start_i = 1'b1; value_i = 32'd500;
    @(negedge clk_i);
    value_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    start_i = 1'b0; value_i = 32'd0;
    chk("R9 first done", {31'd0, done_o}, 32'd1);
    chk("R9 first seed", seed_o, 32'h41F8_0000);
    @(negedge clk_i);
    chk("R9 second done", {31'd0, done_o}, 32'd1);
    chk("R9 second seed", seed_o, 32'h477F_FF00);
    @(negedge clk_i);
    chk("R9 done drops", {31'd0, done_o}, 32'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule